// File: doc/BRIEF.md
# UART Transmit Queue with Line Break

This block buffers outgoing bytes for a UART transmitter. A host writes bytes one at a time to a data register through a small register write port. The block holds them in a first-in first-out store and offers the oldest byte to a downstream serializer over a ready/valid handshake. Bytes are offered only while the transmit-enable control bit is set. Clearing that bit pauses draining and keeps everything queued.

The host can read the number of queued bytes at any time, so it can top up the queue in bulk without overrunning it. Two status outputs support interrupt-driven refill. The idle flag is set once the queue and the serializer are both finished. The low-water flag is set while the fill level is under a programmable threshold.

A control write can discard all queued bytes. Another control bit forces the serial line low for as long as it stays set, which sends a break condition. A write to a full queue is dropped and recorded in a sticky error flag.

Top module: `uart_txq`

## Requirements
- R1: After reset the fill count is 0, transmit is disabled, break is off, the low-water threshold is DEPTH/2, the overflow error is clear and `out_valid` is low.
- R2: Each write to address 0 (data register) while the queue is not full appends `wr_data` and raises `fill_level` by one in the following cycle.
- R3: Bytes appear on `out_data` in the order they were written, and each handshake (`out_valid` and `out_ready` both high at a clock edge) advances to the next byte.
- R4: `out_valid` is high only while the enable bit (address 1, bit 0) is set and the queue holds at least one byte. Clearing the enable bit keeps the queued bytes and their order.
- R5: A data write while `fill_level` equals DEPTH is dropped, and it sets `ovf_err`. That flag stays set until a control write (address 1) with bit 3 set clears it.
- R6: `idle` is high exactly when the queue holds no bytes and `ser_busy` is low.
- R7: `low_water` is high exactly when `fill_level` is below the threshold. A write to address 2 loads the threshold from the low bits of `wr_data`.
- R8: While the break bit (address 1, bit 1) is set, `txd` is held at 0. Otherwise `txd` follows `ser_line`.
- R9: A control write with bit 2 set discards every queued byte, so `fill_level` reads 0 in the following cycle.
- R10: A data write and a handshake in the same cycle on a non-full queue leave `fill_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 data, 1 control, 2 threshold |
| wr_data | input | 8 | Register write value |
| fill_level | output | 5 | Number of queued bytes |
| idle | output | 1 | Queue empty and serializer finished |
| low_water | output | 1 | Fill level below threshold |
| ovf_err | output | 1 | Sticky write-while-full flag |
| out_valid | output | 1 | Byte offered to serializer |
| out_data | output | 8 | Oldest queued byte |
| out_ready | input | 1 | Serializer accepts the offered byte |
| ser_busy | input | 1 | Serializer still shifting a byte |
| ser_line | input | 1 | Serial bit stream from serializer |
| txd | output | 1 | Serial output line |

## Verification
The bench builds the block with its default depth of 16 and 8-bit bytes. At that size the queue can be filled to the brim in a few dozen cycles, which puts the dropped 17th write and its sticky flag within reach. It also covers a complete drain that checks byte order across the pointer wrap. The default threshold of 8 lets a short run of writes carry the low-water flag across its edge. Reprogramming the threshold then moves that edge both above and below the current fill.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] REG_THR  = 2'd2;

    localparam int unsigned CTL_EN    = 0;
    localparam int unsigned CTL_BRK   = 1;
    localparam int unsigned CTL_FLUSH = 2;
    localparam int unsigned CTL_CLR   = 3;
endpackage

// File: rtl/uart_txq_regs.sv
module uart_txq_regs
    import uart_txq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              full,
    output logic              push,
    output logic              flush,
    output logic              tx_en,
    output logic              brk,
    output logic [CNT_W-1:0]  thr,
    output logic              err
);
    typedef struct packed {
        logic             en;
        logic             brk;
        logic [CNT_W-1:0] thr;
        logic             err;
    } ctl_t;

    ctl_t c_d, c_q;
    logic ctl_wr;

    always_comb begin
        c_d    = c_q;
        push   = wr_en && (wr_addr == REG_DATA);
        ctl_wr = wr_en && (wr_addr == REG_CTRL);
        flush  = ctl_wr && wr_data[CTL_FLUSH];
        if (ctl_wr) begin
            c_d.en  = wr_data[CTL_EN];
            c_d.brk = wr_data[CTL_BRK];
            if (wr_data[CTL_CLR]) begin
                c_d.err = 1'b0;
            end
        end
        if (wr_en && (wr_addr == REG_THR)) begin
            c_d.thr = CNT_W'(wr_data);
        end
        if (push && full) begin
            c_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.en  <= 1'b0;
            c_q.brk <= 1'b0;
            c_q.thr <= CNT_W'(DEPTH / 2);
            c_q.err <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign tx_en = c_q.en;
    assign brk   = c_q.brk;
    assign thr   = c_q.thr;
    assign err   = c_q.err;
endmodule

// File: rtl/uart_txq_store.sv
module uart_txq_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    head,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PTR_W-1:0]         rd;
        logic [PTR_W-1:0]         wr;
        logic [CNT_W-1:0]         cnt;
    } st_t;

    st_t s_d, s_q;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_push = push && (s_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (s_q.cnt != '0);
        if (flush) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wr] = din;
                s_d.wr          = step(s_q.wr);
            end
            if (do_pop) begin
                s_d.rd = step(s_q.rd);
            end
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head  = s_q.mem[s_q.rd];
    assign count = s_q.cnt;
    assign full  = (s_q.cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/uart_txq_status.sv
module uart_txq_status #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thr,
    input  logic             tx_en,
    input  logic             brk,
    input  logic             out_ready,
    input  logic             ser_busy,
    input  logic             ser_line,
    output logic             out_valid,
    output logic             pop,
    output logic             idle,
    output logic             low_water,
    output logic             txd
);
    logic has_data;

    always_comb begin
        has_data  = (count != '0);
        out_valid = tx_en && has_data;
        pop       = out_valid && out_ready;
        idle      = !has_data && !ser_busy;
        low_water = (count < thr);
        txd       = brk ? 1'b0 : ser_line;
    end
endmodule

// File: rtl/uart_txq.sv
module uart_txq
    import uart_txq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [CNT_W-1:0]  fill_level,
    output logic              idle,
    output logic              low_water,
    output logic              ovf_err,
    output logic              out_valid,
    output logic [DW-1:0]     out_data,
    input  logic              out_ready,
    input  logic              ser_busy,
    input  logic              ser_line,
    output logic              txd
);
    logic             push, flush, pop, full, tx_en, brk;
    logic [CNT_W-1:0] thr;

    uart_txq_regs #(.DEPTH(DEPTH), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .full    (full),
        .push    (push),
        .flush   (flush),
        .tx_en   (tx_en),
        .brk     (brk),
        .thr     (thr),
        .err     (ovf_err)
    );

    uart_txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .flush (flush),
        .din   (wr_data),
        .head  (out_data),
        .count (fill_level),
        .full  (full)
    );

    uart_txq_status #(.DEPTH(DEPTH)) u_status (
        .count     (fill_level),
        .thr       (thr),
        .tx_en     (tx_en),
        .brk       (brk),
        .out_ready (out_ready),
        .ser_busy  (ser_busy),
        .ser_line  (ser_line),
        .out_valid (out_valid),
        .pop       (pop),
        .idle      (idle),
        .low_water (low_water),
        .txd       (txd)
    );
endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk
    import uart_txq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic [CNT_W-1:0]  fill_level,
    input logic              ovf_err,
    input logic              out_valid,
    input logic              out_ready,
    input logic              brk,
    input logic              txd
);
    logic data_wr, ctl_wr, hs;
    assign data_wr = wr_en && (wr_addr == REG_DATA);
    assign ctl_wr  = wr_en && (wr_addr == REG_CTRL);
    assign hs      = out_valid && out_ready;

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CNT_W'(DEPTH));

    p_valid_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (fill_level != '0));

    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && fill_level == CNT_W'(DEPTH) && !hs) |=>
            (fill_level == CNT_W'(DEPTH)) && ovf_err);

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !(ctl_wr && wr_data[CTL_CLR])) |=> ovf_err);

    p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data[CTL_FLUSH]) |=> (fill_level == '0));

    p_push_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && hs && fill_level != CNT_W'(DEPTH)) |=> $stable(fill_level));
endmodule

bind uart_txq uart_txq_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .fill_level (fill_level),
    .ovf_err    (ovf_err),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .brk        (brk),
    .txd        (txd)
);

// File: tb/uart_txq_bench.sv
module uart_txq_bench;
    localparam int DEPTH = 16;
    localparam int NV    = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [4:0] fill_level;
    logic       idle, low_water, ovf_err, out_valid, txd;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;
    logic       ser_busy = 1'b0;
    logic       ser_line = 1'b1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    uart_txq #(.DEPTH(DEPTH), .DW(8)) u_uart_txq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fill_level(fill_level), .idle(idle),
        .low_water(low_water), .ovf_err(ovf_err), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready), .ser_busy(ser_busy),
        .ser_line(ser_line), .txd(txd)
    );

    // {addr[1:0], data[7:0], expected fill[4:0], expected low_water}
    localparam logic [15:0] VEC [0:NV-1] = '{
        {2'd0, 8'h11, 5'd1, 1'b1},
        {2'd0, 8'h22, 5'd2, 1'b1},
        {2'd0, 8'h33, 5'd3, 1'b1},
        {2'd0, 8'h44, 5'd4, 1'b1},
        {2'd0, 8'h55, 5'd5, 1'b1},
        {2'd0, 8'h66, 5'd6, 1'b1},
        {2'd0, 8'h77, 5'd7, 1'b1},
        {2'd0, 8'h88, 5'd8, 1'b0},
        {2'd2, 8'd10, 5'd8, 1'b1},
        {2'd0, 8'h99, 5'd9, 1'b1},
        {2'd2, 8'd4,  5'd9, 1'b0},
        {2'd2, 8'd8,  5'd9, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic take(input string req, input logic [7:0] exp);
        check(req, {31'd0, out_valid}, 32'd1);
        check(req, {24'd0, out_data}, {24'd0, exp});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 fill", fill_level, 0);
        check("R1 valid", out_valid, 0);
        check("R1 err", ovf_err, 0);
        check("R6 idle at reset", idle, 1);
        check("R7 low_water at reset", low_water, 1);
        check("R8 txd follows line", txd, 1);

        // R2 R7 table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][15:14], VEC[i][13:6]);
            check("R2 fill", fill_level, VEC[i][5:1]);
            check("R7 low_water", low_water, VEC[i][0]);
        end

        // R4 disabled keeps data
        repeat (2) @(negedge clk);
        check("R4 no valid when disabled", out_valid, 0);
        check("R4 retained", fill_level, 9);

        // R3 drain in order
        wr(2'd1, 8'h01);
        ser_busy = 1'b1;
        take("R3 b0", 8'h11); take("R3 b1", 8'h22); take("R3 b2", 8'h33);
        // R4 pause mid-stream
        wr(2'd1, 8'h00);
        check("R4 paused valid", out_valid, 0);
        check("R4 paused fill", fill_level, 6);
        wr(2'd1, 8'h01);
        take("R3 b3", 8'h44); take("R3 b4", 8'h55); take("R3 b5", 8'h66);
        take("R3 b6", 8'h77); take("R3 b7", 8'h88); take("R3 b8", 8'h99);
        check("R3 drained", fill_level, 0);
        check("R6 busy keeps idle low", idle, 0);
        ser_busy = 1'b0;
        #1 check("R6 idle after serializer", idle, 1);

        // R10 simultaneous push and pop
        wr(2'd0, 8'hA1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'hA2; out_ready = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; out_ready = 1'b0;
        check("R10 fill unchanged", fill_level, 1);
        check("R10 next byte", out_data, 8'hA2);

        // R9 flush
        wr(2'd1, 8'h04);
        check("R9 flushed", fill_level, 0);
        check("R9 no valid", out_valid, 0);

        // R5 overflow
        for (int i = 0; i < DEPTH; i++) wr(2'd0, 8'h40 + 8'(i));
        check("R5 full", fill_level, 16);
        check("R5 no err yet", ovf_err, 0);
        wr(2'd0, 8'hEE);
        check("R5 drop keeps fill", fill_level, 16);
        check("R5 err set", ovf_err, 1);
        wr(2'd1, 8'h01);
        for (int i = 0; i < DEPTH; i++) take("R5 order after drop", 8'h40 + 8'(i));
        check("R5 empty after drain", fill_level, 0);
        check("R5 err sticky", ovf_err, 1);
        wr(2'd1, 8'h09);
        check("R5 err cleared", ovf_err, 0);

        // R8 break
        wr(2'd1, 8'h03);
        check("R8 break low", txd, 0);
        ser_line = 1'b0; #1;
        ser_line = 1'b1; #1;
        check("R8 break holds", txd, 0);
        wr(2'd1, 8'h01);
        check("R8 released high", txd, 1);
        ser_line = 1'b0; #1;
        check("R8 released follows", txd, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule